// File: doc/BRIEF.md
# Packed Saturating Rounding Multiply-Accumulate Unit

This block is a packed signed multiply-accumulate datapath for a vector unit. It takes two source vectors and an accumulator vector. Each signed lane forms twice the product of the two source lanes. The accumulator lane, moved into the upper half, is added at full precision. The sum is rounded once and shifted down by the lane width. The block saturates that result to the lane's signed range and returns it as the lane's value.

A 2-bit size code selects the lane width, as 8 shifted left by the code value. A width bit selects whether 64 or 128 bits are processed. A scalar bit limits the work to lane 0. Size codes that do not name a supported width are reported on an undefined flag, and they leave the result untouched.

A sticky flag gathers saturation events across operations until a clear input drops it. The result and both flags are registered, so they appear one clock edge after the operation is presented.

Top module: `pk_qdmac`

## Requirements
- R1: Size code 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Lane e of every operand and of the result occupies bits [e*w +: w], where w is the lane width.
- R2: When `valid_i` is high with size code 2'b00 or 2'b11, `undef_o` is 1 after the next clock edge. On that edge `res_o` and `sat_o` keep their previous values. `undef_o` is 0 after any edge that did not see such an illegal operation.
- R3: For each active lane with sources a and b and accumulator c (all signed), the lane result is sat((c*2^w + 2*a*b + 2^(w-1)) >>> w). The product is never saturated on its own.
- R4: The saturation function clamps to the range [-2^(w-1), 2^(w-1)-1].
- R5: In vector mode with `q_i`=0, only the lanes in the low 64 bits are processed, and `res_o[127:64]` is zero.
- R6: With `scalar_i`=1, only lane 0 is processed and every bit above lane 0 is zero, whatever `q_i` is.
- R7: `sat_o` becomes 1 after a legal operation in which any active lane clamps. It stays 1 until cleared. A lane outside the active set never sets it.
- R8: `clr_sat_i` high at a clock edge clears `sat_o`. If a clamping operation arrives on the same edge, `sat_o` ends at 1.
- R9: While `rst_n` is low, a clock edge sets `res_o`, `undef_o` and `sat_o` to zero.
- R10: A legal operation updates `res_o` on the clock edge at which `valid_i` is sampled high. Without such an operation, `res_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| size_i | input | 2 | Lane size code |
| q_i | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| scalar_i | input | 1 | 1 = process lane 0 only |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| acc_i | input | 128 | Accumulator vector |
| clr_sat_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 128 | Registered packed result |
| undef_o | output | 1 | Illegal size code seen on the previous edge |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The properties assume that the control inputs are at known levels on every clock edge whenever reset is released. They also assume that `valid_i` is low while reset is held, so that `sat_o` can only rise after an accepted legal operation. The bench drives every input on the falling edge and keeps `valid_i` low during reset. Its random operations use all four size codes, so both the legal paths and the illegal-code hold path are reached while the clear input toggles at random.

// File: rtl/pk_qdmac_pkg.sv
package pk_qdmac_pkg;

   typedef enum logic [1:0] {
      SZ_RSV0 = 2'b00,
      SZ_H16  = 2'b01,
      SZ_W32  = 2'b10,
      SZ_RSV3 = 2'b11
   } lane_sz_e;

   function automatic logic sz_legal(input logic [1:0] sz);
      return (sz == SZ_H16) || (sz == SZ_W32);
   endfunction

   function automatic int unsigned sz_width(input logic [1:0] sz);
      return 32'd8 << sz;
   endfunction

endpackage

// File: rtl/pk_qdmac_lane.sv
module pk_qdmac_lane #(
   parameter int LW = 16
) (
   input  logic [LW-1:0] a_i,
   input  logic [LW-1:0] b_i,
   input  logic [LW-1:0] c_i,
   output logic [LW-1:0] res_o,
   output logic          sat_o
);
   localparam int IW = 2*LW + 3;
   localparam int SW = IW - LW;
   localparam logic signed [IW-1:0] RND  = {{(IW-LW){1'b0}}, 1'b1, {(LW-1){1'b0}}};
   localparam logic signed [SW-1:0] MAXV = {{(SW-LW+1){1'b0}}, {(LW-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {{(SW-LW+1){1'b1}}, {(LW-1){1'b0}}};

   logic signed [IW-1:0] ax, bx, cx, prod, wide;
   logic signed [SW-1:0] shr;
   logic                 hi, lo;

   always_comb begin
      ax    = IW'($signed(a_i));
      bx    = IW'($signed(b_i));
      cx    = IW'($signed(c_i));
      prod  = ax * bx;
      wide  = (cx <<< LW) + (prod <<< 1) + RND;
      shr   = wide[IW-1:LW];
      hi    = shr > MAXV;
      lo    = shr < MINV;
      sat_o = hi | lo;
      if (hi)      res_o = MAXV[LW-1:0];
      else if (lo) res_o = MINV[LW-1:0];
      else         res_o = shr[LW-1:0];
   end
endmodule

// File: rtl/pk_qdmac_bank.sv
module pk_qdmac_bank #(
   parameter int DATA_W = 128,
   parameter int LW     = 16
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] c_i,
   input  logic              q_i,
   input  logic              scalar_i,
   output logic [DATA_W-1:0] res_o,
   output logic              sat_o
);
   localparam int NL = DATA_W / LW;

   logic [NL-1:0] en, lsat;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0] lres;
      pk_qdmac_lane #(.LW(LW)) u_lane (
         .a_i   (a_i[i*LW +: LW]),
         .b_i   (b_i[i*LW +: LW]),
         .c_i   (c_i[i*LW +: LW]),
         .res_o (lres),
         .sat_o (lsat[i])
      );
      assign en[i] = scalar_i ? (i == 0) : (q_i || (i < NL/2));
      assign res_o[i*LW +: LW] = en[i] ? lres : '0;
   end

   assign sat_o = |(lsat & en);
endmodule

// File: rtl/pk_qdmac.sv
module pk_qdmac
   import pk_qdmac_pkg::*;
#(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [1:0]        size_i,
   input  logic              q_i,
   input  logic              scalar_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic              clr_sat_i,
   output logic [DATA_W-1:0] res_o,
   output logic              undef_o,
   output logic              sat_o
);
   localparam int W_NARROW = 16;
   localparam int W_WIDE   = 32;

   if (DATA_W < 64 || (DATA_W % 64) != 0) begin : g_bad_width
      $error("pk_qdmac: DATA_W must be a positive multiple of 64");
   end

   logic [DATA_W-1:0] r16, r32, rsel;
   logic              s16, s32, ssel, legal, take;

   pk_qdmac_bank #(.DATA_W(DATA_W), .LW(W_NARROW)) u_bank16 (
      .a_i(src_a_i), .b_i(src_b_i), .c_i(acc_i),
      .q_i(q_i), .scalar_i(scalar_i), .res_o(r16), .sat_o(s16)
   );

   pk_qdmac_bank #(.DATA_W(DATA_W), .LW(W_WIDE)) u_bank32 (
      .a_i(src_a_i), .b_i(src_b_i), .c_i(acc_i),
      .q_i(q_i), .scalar_i(scalar_i), .res_o(r32), .sat_o(s32)
   );

   always_comb begin
      legal = sz_legal(size_i);
      take  = valid_i && legal;
      rsel  = (size_i == SZ_W32) ? r32 : r16;
      ssel  = (size_i == SZ_W32) ? s32 : s16;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o   <= '0;
         undef_o <= 1'b0;
         sat_o   <= 1'b0;
      end else begin
         undef_o <= valid_i && !legal;
         if (take) res_o <= rsel;
         sat_o <= (sat_o && !clr_sat_i) || (take && ssel);
      end
   end
endmodule

// File: rtl/pk_qdmac_chk.sv
module pk_qdmac_chk #(
   parameter int DATA_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_i,
   input logic [1:0]        size_i,
   input logic              q_i,
   input logic              scalar_i,
   input logic              clr_sat_i,
   input logic [DATA_W-1:0] res_o,
   input logic              undef_o,
   input logic              sat_o
);
   logic bad_sz;
   assign bad_sz = (size_i == 2'b00) || (size_i == 2'b11);

   p_undef_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && bad_sz) |=> (undef_o && $stable(res_o)));

   p_undef_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && bad_sz) |=> !undef_o);

   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !bad_sz && !q_i && !scalar_i) |=> (res_o[DATA_W-1:64] == '0));

   p_scalar_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && size_i == 2'b01 && scalar_i) |=> (res_o[DATA_W-1:16] == '0));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_o && !clr_sat_i) |=> sat_o);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sat_i && !valid_i) |=> !sat_o);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(res_o));
endmodule

bind pk_qdmac pk_qdmac_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .size_i(size_i),
   .q_i(q_i), .scalar_i(scalar_i), .clr_sat_i(clr_sat_i),
   .res_o(res_o), .undef_o(undef_o), .sat_o(sat_o)
);

// File: tb/pk_qdmac_bench.sv
module pk_qdmac_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [1:0]   size_i = 2'b01;
   logic         q_i = 1'b0;
   logic         scalar_i = 1'b0;
   logic [127:0] src_a_i = '0, src_b_i = '0, acc_i = '0;
   logic         clr_sat_i = 1'b0;
   logic [127:0] res_o;
   logic         undef_o, sat_o;

   int           n_chk = 0, n_bad = 0;
   logic [127:0] exp_res = '0;
   logic         exp_sat = 1'b0;

   always #5 clk = ~clk;

   pk_qdmac u_pk_qdmac (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .size_i(size_i),
      .q_i(q_i), .scalar_i(scalar_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
      .acc_i(acc_i), .clr_sat_i(clr_sat_i), .res_o(res_o),
      .undef_o(undef_o), .sat_o(sat_o)
   );

   function automatic logic [127:0] ref_calc(
      input logic [127:0] a, b, c, input logic [1:0] sz,
      input logic q, sc, output logic s);
      int w = (sz == 2'b01) ? 16 : 32;
      int n = sc ? 1 : ((q ? 128 : 64) / w);
      logic signed [71:0] ea, eb, ec, t, mx, mn;
      logic [127:0] r = '0;
      s = 1'b0;
      mx = (72'sd1 <<< (w-1)) - 72'sd1;
      mn = -(72'sd1 <<< (w-1));
      for (int e = 0; e < n; e++) begin
         if (w == 16) begin
            ea = $signed(a[e*16 +: 16]); eb = $signed(b[e*16 +: 16]); ec = $signed(c[e*16 +: 16]);
         end else begin
            ea = $signed(a[e*32 +: 32]); eb = $signed(b[e*32 +: 32]); ec = $signed(c[e*32 +: 32]);
         end
         t = (ec <<< w) + 72'sd2 * ea * eb + (72'sd1 <<< (w-1));
         t = t >>> w;
         if (t > mx) begin t = mx; s = 1'b1; end
         else if (t < mn) begin t = mn; s = 1'b1; end
         if (w == 16) r[e*16 +: 16] = t[15:0];
         else         r[e*32 +: 32] = t[31:0];
      end
      return r;
   endfunction

   task automatic check_res(input string tag);
      n_chk++;
      if (res_o !== exp_res) begin
         n_bad++;
         $display("FAIL %s res_o actual=%h expected=%h", tag, res_o, exp_res);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [127:0] a, b, c, input logic [1:0] sz,
                         input logic q, sc, clr, input string tag);
      logic s;
      logic [127:0] r;
      logic ok;
      ok = (sz == 2'b01) || (sz == 2'b10);
      r = ref_calc(a, b, c, sz, q, sc, s);
      @(negedge clk);
      src_a_i = a; src_b_i = b; acc_i = c; size_i = sz;
      q_i = q; scalar_i = sc; clr_sat_i = clr; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0; clr_sat_i = 1'b0;
      if (ok) exp_res = r;
      exp_sat = (exp_sat && !clr) || (ok && s);
      check_res(tag);
      check_bit({tag, " R2 undef_o"}, undef_o, !ok);
      check_bit({tag, " R7/R8 sat_o"}, sat_o, exp_sat);
   endtask

   task automatic clear_only();
      @(negedge clk);
      clr_sat_i = 1'b1;
      @(negedge clk);
      clr_sat_i = 1'b0;
      exp_sat = 1'b0;
      check_bit("R8 clear alone", sat_o, 1'b0);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [127:0] neg16, neg32, max16, max32;
      void'($urandom(32'd20240611));
      neg16 = {8{16'h8000}}; neg32 = {4{32'h8000_0000}};
      max16 = {8{16'h7FFF}}; max32 = {4{32'h7FFF_FFFF}};
      repeat (3) @(negedge clk);
      check_res("R9 reset res_o");
      check_bit("R9 reset undef_o", undef_o, 1'b0);
      check_bit("R9 reset sat_o", sat_o, 1'b0);
      rst_n = 1'b1;

      // R1 R3 simple values, both widths
      run_op({8{16'h0100}}, {8{16'h0200}}, {8{16'h0003}}, 2'b01, 1'b1, 1'b0, 1'b0, "R1 R3 16b");
      run_op({4{32'h0001_0000}}, {4{32'h0003_0000}}, {4{32'hFFFF_FFF0}}, 2'b10, 1'b1, 1'b0, 1'b0, "R1 R3 32b");
      // R4 most-negative corners, both widths and widths of vector
      run_op(neg16, neg16, '0, 2'b01, 1'b1, 1'b0, 1'b0, "R4 neg*neg 16b q1");
      clear_only();
      run_op(neg16, neg16, '0, 2'b01, 1'b0, 1'b0, 1'b0, "R4 R5 neg*neg 16b q0");
      run_op(neg32, neg32, '0, 2'b10, 1'b1, 1'b0, 1'b0, "R4 neg*neg 32b q1");
      run_op(neg32, neg32, neg32, 2'b10, 1'b0, 1'b0, 1'b0, "R4 R5 neg*neg 32b q0");
      run_op(max16, neg16, neg16, 2'b01, 1'b1, 1'b0, 1'b0, "R4 low clamp 16b");
      // R7 inactive upper lanes must not set the flag
      clear_only();
      run_op({neg32[127:64], 64'h0}, {neg32[127:64], 64'h0}, {max32[127:64], 64'h0},
             2'b10, 1'b0, 1'b0, 1'b0, "R5 R7 inactive lanes");
      // R6 scalar
      run_op(max32, max32, max32, 2'b01, 1'b1, 1'b1, 1'b0, "R6 scalar 16b");
      run_op(neg32, neg32, '0, 2'b10, 1'b1, 1'b1, 1'b0, "R6 scalar 32b");
      // R8 clear and clamp on the same edge
      run_op(neg16, neg16, '0, 2'b01, 1'b1, 1'b0, 1'b1, "R8 clr with clamp");
      // R2 illegal codes hold result and flag
      run_op(rnd128(), rnd128(), rnd128(), 2'b00, 1'b1, 1'b0, 1'b0, "R2 size 00");
      run_op(neg16, neg16, '0, 2'b11, 1'b1, 1'b0, 1'b0, "R2 size 11");
      // R10 idle hold
      @(negedge clk);
      @(negedge clk);
      check_res("R10 idle hold");

      for (int i = 0; i < 400; i++) begin
         logic [127:0] a, b, c;
         logic [1:0]   sz;
         a = rnd128(); b = rnd128(); c = rnd128();
         if ($urandom_range(3) == 0) begin a = neg32; b = neg32; end
         sz = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : ($urandom_range(1) ? 2'b01 : 2'b10);
         run_op(a, b, c, sz, 1'($urandom_range(1)), ($urandom_range(5) == 0),
                ($urandom_range(4) == 0), "R3 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule